// File: doc/BRIEF.md
# Shuffled-Register Iterative Round Datapath

This block sequences an iterative cipher round built from four combinational stage functions that always run in one fixed logical order. Two pipeline registers close the loop between the stages. For every operation, a random code picks the two inter-stage positions where these registers sit, and both registers may share one position. The stage functions are outside the block. Each one is reached through its own request bus (`stage_in_o`) and response bus (`stage_out_i`), so a design can attach the real cipher functions and a bench can attach simple stand-ins.

Changing the placement changes the cycle in which any given intermediate value reaches a given stage. The total latency stays the same. Before the data enters, both registers are filled with random words, so the first register transitions do not depend on the data or on the placement. An operation is 11 passes through the four stages, with two register steps per pass. After that, the value at the loop's wrap point is captured into an output register and `done_o` pulses for one cycle. A flag tells the mixing stage when its request belongs to the final pass, so that stage can be bypassed there.

The controller has six states:
- `ST_IDLE`: waits for `start_i`, then goes to `ST_DRAW` and latches `data_i`.
- `ST_DRAW`: samples `sel_rnd_i`. It stays in `ST_DRAW` on a rejected code and goes to `ST_PRE0` on an accepted one.
- `ST_PRE0`: fills the first register, then goes to `ST_PRE1`.
- `ST_PRE1`: fills the second register, then goes to `ST_RUN`.
- `ST_RUN`: counts 22 stepping cycles and one capture cycle, then goes to `ST_DONE`.
- `ST_DONE`: pulses `done_o`, then returns to `ST_IDLE`.

Top module: `rrp_round_dp`

## Requirements
- R1: The stages are indexed 0 = key addition, 1 = byte substitution, 2 = row shift, 3 = column mix, and every pass applies them in that index order. `result_o` equals 11 successive passes applied to `data_i`, where the final pass uses stage 3 with `last_o` high.
- R2: Placement code k in 0..9 selects the register positions (lo, hi), where position j means "after stage j". The codes follow the order (0,0),(0,1),(0,2),(0,3),(1,1),(1,2),(1,3),(2,2),(2,3),(3,3). The first register sits at lo and the second at hi.
- R3: In `ST_DRAW`, a code of 10 to 15 is rejected and a fresh code is sampled in the next cycle. Each rejection delays completion by exactly one cycle.
- R4: The first register is loaded with `fill_rnd_i` in the cycle after the accepted draw, and the second register one cycle later. In run cycle 0, stage 1 receives the second preload word under code 0 and the first preload word under codes 1 to 3.
- R5: `done_o` rises exactly 27 cycles after the cycle in which `start_i` is sampled in `ST_IDLE`, plus one cycle per rejected code. This holds for every placement.
- R6: The placement is fixed from the accepted draw until `done_o`. A `start_i` pulse outside `ST_IDLE` is ignored: it produces no extra completion and has no effect on the result.
- R7: `done_o` is high for exactly one cycle per operation. `result_o` changes only in that cycle and holds its value until the next completion.
- R8: `last_o` is high for exactly one cycle per operation. Counting run cycles from 0, it is high in cycle 20 when lo = 3, in cycle 21 when hi = 3 and lo < 3, and in cycle 22 otherwise.
- R9: After reset, `done_o` and `last_o` are low and `result_o` is zero.
- R10: The stage-0 output of pass 0 first reaches stage 1 in run cycle 0 when lo ≥ 1, in run cycle 1 when lo = 0 and hi ≥ 1, and in run cycle 2 when lo = hi = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (honoured only when idle) |
| data_i | input | DATA_W | Input block, latched when the start is accepted |
| sel_rnd_i | input | SEL_W | Random placement code, sampled while drawing |
| fill_rnd_i | input | DATA_W | Random word used to preload the registers |
| stage_in_o | output | NSTG×DATA_W | Request bus to each stage function |
| stage_out_i | input | NSTG×DATA_W | Response bus from each stage function |
| last_o | output | 1 | The stage-3 request in this cycle belongs to the final pass |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Captured result |

## Verification
The bench runs every one of the ten placement codes on the same input block. Identical results across the codes show that the placement never alters the function. The `last_o` cycle and the cycle in which the first stage-0 output reaches stage 1 separate the placements that share a timing group. Distinct preload words show which register feeds stage 1 in the first run cycle. Streams that contain rejected codes show the one-cycle-per-rejection shift. A start pulse injected mid-run with a different input block shows that the running operation stays intact.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

    localparam int NSTG   = 4;
    localparam int PW     = 2;
    localparam int NPLACE = NSTG * (NSTG + 1) / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAW,
        ST_PRE0,
        ST_PRE1,
        ST_RUN,
        ST_DONE
    } state_t;

    typedef struct packed {
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
    } place_t;

    // Codes enumerate (lo,hi) with lo <= hi in lexicographic order.
    function automatic place_t code_to_place(input logic [3:0] code);
        place_t p;
        int     idx;
        p   = '0;
        idx = 0;
        for (int a = 0; a < NSTG; a++) begin
            for (int b = a; b < NSTG; b++) begin
                if (idx == int'(code)) begin
                    p.lo = PW'(a);
                    p.hi = PW'(b);
                end
                idx++;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/rrp_ctrl.sv
module rrp_ctrl
    import rrp_pkg::*;
#(
    parameter int PASSES = 11,
    parameter int SEL_W  = 4,
    localparam int RUN_CYC = PASSES * 2,
    localparam int CNT_W   = $clog2(RUN_CYC + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [SEL_W-1:0] sel_i,
    output state_t           state_o,
    output logic [CNT_W-1:0] cnt_o,
    output place_t           place_o,
    output logic             load_in_o,
    output logic             pre0_o,
    output logic             pre1_o,
    output logic             step_o,
    output logic             first_o,
    output logic             capture_o,
    output logic             last_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RUN_CYC);
    localparam logic [PW-1:0]    TOP_POS = PW'(NSTG - 1);

    state_t           state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    place_t           place_q;
    logic             sel_ok;
    logic [CNT_W-1:0] last_cyc;

    assign sel_ok = (sel_i < SEL_W'(NPLACE));

    // State register, run counter and latched placement.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            place_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_RUN) ? cnt_q + 1'b1 : '0;
            if (state_q == ST_DRAW && sel_ok) begin
                place_q <= code_to_place(4'(sel_i));
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_DRAW;
            ST_DRAW: if (sel_ok)  state_d = ST_PRE0;
            ST_PRE0: state_d = ST_PRE1;
            ST_PRE1: state_d = ST_RUN;
            ST_RUN:  if (cnt_q == CNT_END) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Cycle in which stage 3 handles the final pass.
    always_comb begin
        if (place_q.lo == TOP_POS)      last_cyc = CNT_END - CNT_W'(2);
        else if (place_q.hi == TOP_POS) last_cyc = CNT_END - CNT_W'(1);
        else                            last_cyc = CNT_END;
    end

    // Output decode from the state register.
    always_comb begin
        load_in_o = (state_q == ST_IDLE) && start_i;
        pre0_o    = (state_q == ST_PRE0);
        pre1_o    = (state_q == ST_PRE1);
        step_o    = (state_q == ST_RUN) && (cnt_q != CNT_END);
        first_o   = (state_q == ST_RUN) && (cnt_q == '0);
        capture_o = (state_q == ST_RUN) && (cnt_q == CNT_END);
        last_o    = (state_q == ST_RUN) && (cnt_q == last_cyc);
        done_o    = (state_q == ST_DONE);
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign place_o = place_q;

endmodule

// File: rtl/rrp_ring.sv
module rrp_ring
    import rrp_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       load_in_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic [DATA_W-1:0]          fill_i,
    input  logic                       pre0_i,
    input  logic                       pre1_i,
    input  logic                       step_i,
    input  logic                       first_i,
    input  logic                       capture_i,
    input  place_t                     place_i,
    input  logic [NSTG-1:0][DATA_W-1:0] stage_out_i,
    output logic [NSTG-1:0][DATA_W-1:0] stage_in_o,
    output logic [DATA_W-1:0]          result_o
);

    localparam logic [PW-1:0] TOP_POS = PW'(NSTG - 1);

    logic [DATA_W-1:0] in_q, r0_q, r1_q, res_q, wrap;

    // Each stage reads the register at its entry position, or its predecessor.
    for (genvar gi = 0; gi < NSTG; gi++) begin : g_mux
        localparam logic [PW-1:0] PREV_P = PW'((gi + NSTG - 1) % NSTG);
        logic [DATA_W-1:0] pick;
        always_comb begin
            if (gi == 0 && first_i)        pick = in_q;
            else if (place_i.hi == PREV_P) pick = r1_q;
            else if (place_i.lo == PREV_P) pick = r0_q;
            else                           pick = stage_out_i[(gi + NSTG - 1) % NSTG];
        end
        assign stage_in_o[gi] = pick;
    end

    assign wrap = (place_i.hi == TOP_POS) ? r1_q : stage_out_i[NSTG-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            in_q  <= '0;
            r0_q  <= '0;
            r1_q  <= '0;
            res_q <= '0;
        end else begin
            if (load_in_i) in_q <= data_i;
            if (pre0_i)    r0_q <= fill_i;
            if (pre1_i)    r1_q <= fill_i;
            if (step_i) begin
                r0_q <= stage_out_i[place_i.lo];
                r1_q <= (place_i.lo == place_i.hi) ? r0_q : stage_out_i[place_i.hi];
            end
            if (capture_i) res_q <= wrap;
        end
    end

    assign result_o = res_q;

endmodule

// File: rtl/rrp_round_dp.sv
module rrp_round_dp
    import rrp_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int PASSES = 11,
    parameter int SEL_W  = 4,
    localparam int CNT_W = $clog2(PASSES * 2 + 1)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        start_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic [SEL_W-1:0]            sel_rnd_i,
    input  logic [DATA_W-1:0]           fill_rnd_i,
    output logic [NSTG-1:0][DATA_W-1:0] stage_in_o,
    input  logic [NSTG-1:0][DATA_W-1:0] stage_out_i,
    output logic                        last_o,
    output logic                        done_o,
    output logic [DATA_W-1:0]           result_o
);

    state_t           state_w;
    logic [CNT_W-1:0] cnt_w;
    place_t           place_w;
    logic load_in_w, pre0_w, pre1_w, step_w, first_w, capture_w;

    rrp_ctrl #(.PASSES(PASSES), .SEL_W(SEL_W)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .sel_i     (sel_rnd_i),
        .state_o   (state_w),
        .cnt_o     (cnt_w),
        .place_o   (place_w),
        .load_in_o (load_in_w),
        .pre0_o    (pre0_w),
        .pre1_o    (pre1_w),
        .step_o    (step_w),
        .first_o   (first_w),
        .capture_o (capture_w),
        .last_o    (last_o),
        .done_o    (done_o)
    );

    rrp_ring #(.DATA_W(DATA_W)) u_ring (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_in_i   (load_in_w),
        .data_i      (data_i),
        .fill_i      (fill_rnd_i),
        .pre0_i      (pre0_w),
        .pre1_i      (pre1_w),
        .step_i      (step_w),
        .first_i     (first_w),
        .capture_i   (capture_w),
        .place_i     (place_w),
        .stage_out_i (stage_out_i),
        .stage_in_o  (stage_in_o),
        .result_o    (result_o)
    );

endmodule

// File: rtl/rrp_round_dp_chk.sv
module rrp_round_dp_chk
    import rrp_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int SEL_W  = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [SEL_W-1:0]  sel_rnd_i,
    input logic              done_o,
    input logic              last_o,
    input logic [DATA_W-1:0] result_o,
    input state_t            state,
    input logic [CNT_W-1:0]  cnt,
    input place_t            place
);

    assert_placement_ordered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RUN) |-> (place.lo <= place.hi));

    assert_reject_redraws_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_DRAW && sel_rnd_i >= SEL_W'(NPLACE)) |=> (state == ST_DRAW));

    assert_placement_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_PRE1 || state == ST_RUN || state == ST_DONE) |-> $stable(place));

    assert_busy_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RUN && start_i) |=> (state == ST_RUN || state == ST_DONE));

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_result_moves_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> done_o);

    assert_last_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> !last_o);

    assert_last_only_running_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |-> (state == ST_RUN && cnt >= CNT_W'(20)));

endmodule

bind rrp_round_dp rrp_round_dp_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sel_rnd_i (sel_rnd_i),
    .done_o    (done_o),
    .last_o    (last_o),
    .result_o  (result_o),
    .state     (state_w),
    .cnt       (cnt_w),
    .place     (place_w)
);

// File: tb/rrp_round_dp_tb_top.sv
module rrp_round_dp_tb_top;

    localparam int DW = 32;
    localparam logic [DW-1:0] C0 = 32'h5A3C_96E1;
    localparam logic [DW-1:0] C1 = 32'h0123_4567;
    localparam logic [DW-1:0] W0 = 32'hA5A5_0F0F;
    localparam logic [DW-1:0] W1 = 32'h3C3C_F0F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] data = '0;
    logic [3:0] sel = '0;
    logic [DW-1:0] fill = '0;
    logic [3:0][DW-1:0] s_in, s_out;
    logic last, done;
    logic [DW-1:0] result;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    // Stand-in stage functions, index order: key add, substitute, shift, mix.
    assign s_out[0] = s_in[0] ^ C0;
    assign s_out[1] = s_in[1] + C1;
    assign s_out[2] = {s_in[2][23:0], s_in[2][31:24]};
    assign s_out[3] = last ? s_in[3] : (s_in[3] ^ {s_in[3][30:0], 1'b0});

    rrp_round_dp #(.DATA_W(DW), .PASSES(11), .SEL_W(4)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .data_i      (data),
        .sel_rnd_i   (sel),
        .fill_rnd_i  (fill),
        .stage_in_o  (s_in),
        .stage_out_i (s_out),
        .last_o      (last),
        .done_o      (done),
        .result_o    (result)
    );

    function automatic logic [DW-1:0] model(input logic [DW-1:0] pt);
        logic [DW-1:0] x;
        x = pt;
        for (int p = 0; p < 11; p++) begin
            x = x ^ C0;
            x = x + C1;
            x = {x[23:0], x[31:24]};
            if (p != 10) x = x ^ {x[30:0], 1'b0};
        end
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic decode(input int code, output int lo, output int hi);
        int idx = 0;
        lo = 0;
        hi = 0;
        for (int a = 0; a < 4; a++)
            for (int b = a; b < 4; b++) begin
                if (idx == code) begin lo = a; hi = b; end
                idx++;
            end
    endtask

    task automatic run_op(input logic [DW-1:0] pt, input int code, input int nrej,
                          input bit poke, input bit deep);
        int lo, hi, done_k, done_n, last_c, last_n, hit_c, exp_last, exp_hit;
        logic [DW-1:0] c0_val, res_val, exp_c0;
        decode(code, lo, hi);
        done_k = -1; done_n = 0; last_c = -1; last_n = 0; hit_c = -1;
        c0_val = '0; res_val = '0;
        @(negedge clk);
        start = 1'b1; data = pt; sel = 4'd15;
        for (int k = 1; k <= nrej + 32; k++) begin
            int c;
            @(negedge clk);
            start = poke && (k == 10);
            data  = (poke && k == 10) ? ~pt : pt;
            sel   = (k <= nrej) ? 4'(10 + (k % 6)) : 4'(code);
            fill  = (k == nrej + 2) ? W0 : (k == nrej + 3) ? W1 : 32'hDEAD_BEEF;
            #1;
            c = k - (nrej + 4);
            if (c >= 0 && c <= 22 && last) begin last_n++; last_c = c; end
            if (c == 0) c0_val = s_in[1];
            if (c >= 0 && c <= 3 && hit_c < 0 && s_in[1] == (pt ^ C0)) hit_c = c;
            if (done) begin
                done_n++;
                if (done_k < 0) begin done_k = k; res_val = result; end
            end
        end
        exp_last = (lo == 3) ? 20 : (hi == 3) ? 21 : 22;
        chk(res_val == model(pt), "R1 result", res_val, model(pt));
        chk(done_k == nrej + 27, "R5 latency (R3 with rejections)", done_k, nrej + 27);
        chk(done_n == 1, "R7 done pulse count (R6 when poked)", done_n, 1);
        chk(result == res_val, "R7 result held", result, res_val);
        chk(last_n == 1 && last_c == exp_last, "R8 last cycle", last_c, exp_last);
        if (deep) begin
            exp_hit = (lo >= 1) ? 0 : (hi >= 1) ? 1 : 2;
            chk(hit_c == exp_hit, "R10 intermediate timing (R2 placement)", hit_c, exp_hit);
            exp_c0 = (lo >= 1) ? (pt ^ C0) : (hi == 0) ? W1 : W0;
            chk(c0_val == exp_c0, "R4 preload seen by stage 1", c0_val, exp_c0);
        end
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R9 done low", done, 0);
        chk(last == 1'b0, "R9 last low", last, 0);
        chk(result == '0, "R9 result zero", result, 0);
    endtask

    task automatic t_all_codes;
        for (int code = 0; code < 10; code++) run_op(32'h1357_9BDF, code, 0, 1'b0, 1'b1);
    endtask

    task automatic t_data_patterns;
        run_op(32'h0000_0000, 5, 0, 1'b0, 1'b1);
        run_op(32'hFFFF_FFFF, 9, 0, 1'b0, 1'b1);
        run_op(32'h8000_0001, 0, 0, 1'b0, 1'b1);
    endtask

    task automatic t_rejects;
        run_op(32'hCAFE_F00D, 3, 1, 1'b0, 1'b1);
        run_op(32'h0BEE_F123, 7, 3, 1'b0, 1'b1);
    endtask

    task automatic t_busy_start;
        run_op(32'h2468_ACE0, 6, 0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R6 no extra completion after busy start", done, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_all_codes;
        t_data_patterns;
        t_rejects;
        t_busy_start;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule